// File: doc/BRIEF.md
# Six-Stage Pipeline Occupancy Controller

This block models how instruction tokens move through a six-stage in-order pipeline: instruction fetch, decode, operand address calculation, operand fetch, execute and write-back. Stage 0 is fetch and stage 5 is write-back. The block carries no datapath. Each stage holds only a valid flag and the tag of the instruction it contains. With every stage filled, six instructions are in flight at once.

Each stage has its own stall request. A stall freezes that stage and every younger stage behind it. The stages ahead of it keep draining, so the stage directly ahead of the stall receives a bubble.

Branches resolve only in write-back. A taken-branch pulse while write-back holds an instruction flushes every younger instruction, and a one-cycle flush output reports it. A saturating counter adds up empty stage-cycles so that a bench or a performance monitor can measure pipeline waste.

Top module: `pipe_occupancy_ctl`

## Requirements
- R1: When `in_ready` and `in_valid` are both 1, the next clock edge loads fetch (stage 0) with valid 1 and tag `in_tag`.
- R2: With no stall and no flush, each stage i>0 takes the valid flag and tag of stage i-1 at the clock edge. The instruction in write-back (stage 5) leaves the pipeline.
- R3: A stall request on stage k freezes stages 0..k, keeping their valid flags and tags. This applies even when those stages are empty. Bit i of `stall_req` belongs to stage i.
- R4: When stage k is frozen and stage k+1 is not, stage k+1 becomes empty (a bubble) at the next edge.
- R5: Stages ahead of the highest stalled stage keep advancing as in R2 while the stall lasts.
- R6: `in_ready` is 0 whenever fetch is frozen or a flush occurs. When `in_ready` is 0, `in_valid` and `in_tag` are ignored.
- R7: `flush` is 1 exactly when `br_taken` is 1 and write-back holds an instruction. `br_taken` has no effect while write-back is empty.
- R8: A flush takes priority over every stall. After the flush edge, all six stages are empty, including fetch.
- R9: At each clock edge, `bubble_cnt` grows by the number of stages that were empty before that edge. It saturates at 2^CNT_W-1.
- R10: While reset is active, all stages are empty, `bubble_cnt` is 0, `flush` is 0 and `in_ready` is 1. Reset is asserted asynchronously and released through a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New instruction offered to fetch |
| in_tag | input | TAG_W | Tag of the offered instruction |
| stall_req | input | 6 | Per-stage stall request, bit i for stage i |
| br_taken | input | 1 | Branch in write-back resolved as taken |
| in_ready | output | 1 | Fetch accepts the offered instruction this cycle |
| stg_valid | output | 6 | Occupancy flag of each stage, bit i for stage i |
| stg_tag | output | 6*TAG_W | Tag of each stage, stage i in bits [i*TAG_W +: TAG_W] |
| bubble_cnt | output | CNT_W | Saturating count of empty stage-cycles |
| flush | output | 1 | Taken-branch flush this cycle |

## Verification
The clocked properties assume that `stall_req`, `br_taken`, `in_valid` and `in_tag` carry known values on every edge after reset. They also assume that a producer offers an instruction only through `in_valid` and treats `in_ready` as the acceptance signal. The stimulus changes every input on the falling edge and always drives defined values. It offers instructions while fetch is frozen and pulses `br_taken` while write-back is empty, so that the "ignored" cases of R6 and R7 are observed at the outputs. It also applies a flush and a stall together, which exercises the priority rule of R8.

// File: rtl/pipe_occ_pkg.sv
package pipe_occ_pkg;

  localparam int unsigned NUM_STAGES = 6;

  typedef enum logic [2:0] {
    STG_FETCH  = 3'd0,
    STG_DECODE = 3'd1,
    STG_ADDR   = 3'd2,
    STG_OPND   = 3'd3,
    STG_EXEC   = 3'd4,
    STG_WB     = 3'd5
  } stage_e;

  localparam int unsigned FIRST_STG = int'(STG_FETCH);
  localparam int unsigned LAST_STG  = int'(STG_WB);

endpackage

// File: rtl/pipe_rst_sync.sv
module pipe_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/pipe_hold_chain.sv
module pipe_hold_chain #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] stall_req,
  output logic [N-1:0] hold
);
  // A stall freezes its own stage and every younger (lower index) stage.
  assign hold[N-1] = stall_req[N-1];

  for (genvar i = 0; i < N-1; i++) begin : g_chain
    assign hold[i] = stall_req[i] | hold[i+1];
  end
endmodule

// File: rtl/pipe_stage.sv
module pipe_stage #(
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             hold_i,
  input  logic             bubble_i,
  input  logic             up_valid_i,
  input  logic [TAG_W-1:0] up_tag_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o
);
  logic             valid_q, valid_d;
  logic [TAG_W-1:0] tag_q;
  logic             tag_en;

  always_comb begin
    valid_d = valid_q;
    tag_en  = 1'b0;
    if (flush_i) begin
      valid_d = 1'b0;
    end else if (hold_i) begin
      valid_d = valid_q;
    end else if (bubble_i) begin
      valid_d = 1'b0;
    end else begin
      valid_d = up_valid_i;
      tag_en  = up_valid_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (tag_en) begin
      tag_q <= up_tag_i;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;

  // R3: a frozen stage keeps its occupancy and tag
  p_hold_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && hold_i) |=> ($stable(valid_q) && $stable(tag_q)));
endmodule

// File: rtl/pipe_bubble_counter.sv
module pipe_bubble_counter #(
  parameter int unsigned N     = 6,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned ADD_W = $clog2(N + 1);
  localparam int unsigned SUM_W = CNT_W + ADD_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ADD_W-1:0] empties;
  logic [SUM_W-1:0] sum;

  always_comb begin
    empties = '0;
    for (int i = 0; i < int'(N); i++) begin
      empties = empties + ADD_W'(!valid_i[i]);
    end
    sum = SUM_W'(cnt_q) + SUM_W'(empties);
    if (sum > SUM_W'(CNT_MAX)) begin
      cnt_d = CNT_MAX;
    end else begin
      cnt_d = sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R9: the count never falls while running
  p_cnt_grows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q >= $past(cnt_q)));
  // R9: saturation holds
  p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/pipe_occupancy_ctl.sv
module pipe_occupancy_ctl
  import pipe_occ_pkg::*;
#(
  parameter int unsigned TAG_W = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [TAG_W-1:0]            in_tag,
  input  logic [NUM_STAGES-1:0]       stall_req,
  input  logic                        br_taken,
  output logic                        in_ready,
  output logic [NUM_STAGES-1:0]       stg_valid,
  output logic [NUM_STAGES*TAG_W-1:0] stg_tag,
  output logic [CNT_W-1:0]            bubble_cnt,
  output logic                        flush
);
  localparam int unsigned N = NUM_STAGES;

  logic         rst_n_sync;
  logic [N-1:0] hold;

  pipe_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  pipe_hold_chain #(.N(N)) u_hold (
    .stall_req(stall_req),
    .hold     (hold)
  );

  assign flush    = br_taken & stg_valid[LAST_STG];
  assign in_ready = ~hold[FIRST_STG] & ~flush;

  for (genvar i = 0; i < int'(N); i++) begin : g_stage
    logic             up_valid;
    logic [TAG_W-1:0] up_tag;
    logic             bubble;

    if (i == int'(FIRST_STG)) begin : g_head
      assign up_valid = in_valid;
      assign up_tag   = in_tag;
      assign bubble   = 1'b0;
    end else begin : g_body
      assign up_valid = stg_valid[i-1];
      assign up_tag   = stg_tag[(i-1)*TAG_W +: TAG_W];
      assign bubble   = hold[i-1];
    end

    pipe_stage #(.TAG_W(TAG_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n_sync),
      .flush_i   (flush),
      .hold_i    (hold[i]),
      .bubble_i  (bubble),
      .up_valid_i(up_valid),
      .up_tag_i  (up_tag),
      .valid_o   (stg_valid[i]),
      .tag_o     (stg_tag[i*TAG_W +: TAG_W])
    );

    if (i > 0) begin : g_chk
      // R2 / R5: a free stage behind a free stage takes its occupancy
      p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
        (!flush && !hold[i] && !hold[i-1]) |=> (stg_valid[i] == $past(stg_valid[i-1])));
      // R4: the stage ahead of a frozen one turns into a bubble
      p_bubble_ahead_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
        (!flush && hold[i-1] && !hold[i]) |=> !stg_valid[i]);
    end
  end

  pipe_bubble_counter #(.N(N), .CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .valid_i(stg_valid),
    .cnt_o  (bubble_cnt)
  );

  // R1: an accepted instruction appears in fetch with its tag
  p_fetch_load_r1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && in_ready) |=> (stg_valid[FIRST_STG] &&
      stg_tag[FIRST_STG*TAG_W +: TAG_W] == $past(in_tag)));
  // R6: without ready, fetch occupancy is untouched unless flushed
  p_ready_block_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!in_ready && !flush) |=> $stable(stg_valid[FIRST_STG]));
  // R8: a flush empties every stage
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    flush |=> (stg_valid == '0));
  // R7: a flush is a single-cycle pulse
  p_flush_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    flush |=> !flush);
endmodule

// File: tb/pipe_occupancy_ctl_bench.sv
`timescale 1ns/1ps
module pipe_occupancy_ctl_bench;
  localparam int TAG_W = 8;
  localparam int CNT_W = 8;
  localparam int N     = 6;
  localparam int NV    = 18;
  localparam int CMAX  = (1 << CNT_W) - 1;

  typedef struct packed {
    logic          iv;
    logic [7:0]    tag;
    logic [5:0]    st;
    logic          br;
    logic [5:0]    ev;
    logic [47:0]   et;
    logic          ef;
    logic          er;
  } vec_t;

  // stimulus, expected occupancy / tags after the edge, expected flush / ready before it
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'hA1, 6'b000000, 1'b0, 6'b000001, 48'h0000000000A1, 1'b0, 1'b1},
    '{1'b1, 8'hA2, 6'b000000, 1'b0, 6'b000011, 48'h00000000A1A2, 1'b0, 1'b1},
    '{1'b1, 8'hA3, 6'b000000, 1'b0, 6'b000111, 48'h000000A1A2A3, 1'b0, 1'b1},
    '{1'b1, 8'hA4, 6'b000000, 1'b0, 6'b001111, 48'h0000A1A2A3A4, 1'b0, 1'b1},
    '{1'b1, 8'hA5, 6'b000000, 1'b0, 6'b011111, 48'h00A1A2A3A4A5, 1'b0, 1'b1},
    '{1'b1, 8'hA6, 6'b000000, 1'b0, 6'b111111, 48'hA1A2A3A4A5A6, 1'b0, 1'b1},
    '{1'b1, 8'hA7, 6'b001000, 1'b0, 6'b101111, 48'hA200A3A4A5A6, 1'b0, 1'b0},
    '{1'b1, 8'hA7, 6'b000000, 1'b0, 6'b011111, 48'h00A3A4A5A6A7, 1'b0, 1'b1},
    '{1'b1, 8'hA8, 6'b000001, 1'b0, 6'b111101, 48'hA3A4A5A600A7, 1'b0, 1'b0},
    '{1'b1, 8'hA8, 6'b100000, 1'b1, 6'b000000, 48'h000000000000, 1'b1, 1'b0},
    '{1'b1, 8'hB1, 6'b000000, 1'b0, 6'b000001, 48'h0000000000B1, 1'b0, 1'b1},
    '{1'b0, 8'h00, 6'b000100, 1'b0, 6'b000001, 48'h0000000000B1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 6'b000000, 1'b1, 6'b000010, 48'h00000000B100, 1'b0, 1'b1},
    '{1'b1, 8'hB2, 6'b000000, 1'b0, 6'b000101, 48'h000000B100B2, 1'b0, 1'b1},
    '{1'b0, 8'h00, 6'b000000, 1'b0, 6'b001010, 48'h0000B100B200, 1'b0, 1'b1},
    '{1'b0, 8'h00, 6'b000000, 1'b0, 6'b010100, 48'h00B100B20000, 1'b0, 1'b1},
    '{1'b0, 8'h00, 6'b000000, 1'b0, 6'b101000, 48'hB100B2000000, 1'b0, 1'b1},
    '{1'b1, 8'hB3, 6'b000000, 1'b1, 6'b000000, 48'h000000000000, 1'b1, 1'b0}
  };

  logic                clk = 1'b0;
  logic                rst_n;
  logic                in_valid;
  logic [TAG_W-1:0]    in_tag;
  logic [N-1:0]        stall_req;
  logic                br_taken;
  logic                in_ready;
  logic [N-1:0]        stg_valid;
  logic [N*TAG_W-1:0]  stg_tag;
  logic [CNT_W-1:0]    bubble_cnt;
  logic                flush;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pipe_occupancy_ctl #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_pipe_occupancy_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_tag    (in_tag),
    .stall_req (stall_req),
    .br_taken  (br_taken),
    .in_ready  (in_ready),
    .stg_valid (stg_valid),
    .stg_tag   (stg_tag),
    .bubble_cnt(bubble_cnt),
    .flush     (flush)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int empties(input logic [5:0] v);
    int e = 0;
    for (int i = 0; i < N; i++) if (!v[i]) e++;
    return e;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    // R10: asynchronous clear
    check(stg_valid == '0, "R10 valid", longint'(stg_valid), 0);
    check(bubble_cnt == '0, "R10 count", longint'(bubble_cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_cnt;
    logic [5:0] prev_ev;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_tag    = '0;
    stall_req = '0;
    br_taken  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    // R10: state right after reset release
    check(stg_valid == '0, "R10 valid", longint'(stg_valid), 0);
    check(bubble_cnt == '0, "R10 count", longint'(bubble_cnt), 0);
    check(flush == 1'b0, "R10 flush", longint'(flush), 0);
    check(in_ready == 1'b1, "R10 ready", longint'(in_ready), 1);

    // R1 R2 R3 R4 R5 R6 R7 R8 R9: table walk
    exp_cnt = 0;
    prev_ev = '0;
    for (int k = 0; k < NV; k++) begin
      in_valid  = VEC[k].iv;
      in_tag    = VEC[k].tag;
      stall_req = VEC[k].st;
      br_taken  = VEC[k].br;
      #1;
      check(flush == VEC[k].ef, "R7 flush", longint'(flush), longint'(VEC[k].ef));
      check(in_ready == VEC[k].er, "R6 ready", longint'(in_ready), longint'(VEC[k].er));
      @(posedge clk);
      @(negedge clk);
      exp_cnt = exp_cnt + empties(prev_ev);
      if (exp_cnt > CMAX) exp_cnt = CMAX;
      prev_ev = VEC[k].ev;
      check(stg_valid == VEC[k].ev, "R2/R3/R4/R8 valid", longint'(stg_valid), longint'(VEC[k].ev));
      for (int s = 0; s < N; s++) begin
        if (VEC[k].ev[s]) begin
          check(stg_tag[s*TAG_W +: TAG_W] == VEC[k].et[s*8 +: 8], "R1/R5 tag",
                longint'(stg_tag[s*TAG_W +: TAG_W]), longint'(VEC[k].et[s*8 +: 8]));
        end
      end
      check(int'(bubble_cnt) == exp_cnt, "R9 count", longint'(bubble_cnt), longint'(exp_cnt));
    end

    // R9: saturation with an idle pipeline
    in_valid  = 1'b0;
    stall_req = '0;
    br_taken  = 1'b0;
    for (int c = 0; c < 50; c++) begin
      @(posedge clk);
      exp_cnt = exp_cnt + N;
      if (exp_cnt > CMAX) exp_cnt = CMAX;
    end
    @(negedge clk);
    check(int'(bubble_cnt) == CMAX, "R9 saturate", longint'(bubble_cnt), longint'(CMAX));
    @(posedge clk);
    @(negedge clk);
    check(int'(bubble_cnt) == CMAX, "R9 hold at max", longint'(bubble_cnt), longint'(CMAX));

    // R10: reset mid-run with a loaded pipeline
    in_valid = 1'b1;
    in_tag   = 8'hC1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    do_reset();
    check(stg_valid == '0, "R10 after release", longint'(stg_valid), 0);
    check(in_ready == 1'b1, "R10 ready", longint'(in_ready), 1);

    // R3: stall on fetch with an empty pipeline still blocks input
    stall_req = 6'b000001;
    in_valid  = 1'b1;
    in_tag    = 8'hD1;
    #1;
    check(in_ready == 1'b0, "R3/R6 ready", longint'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
    check(stg_valid[0] == 1'b0, "R6 ignored", longint'(stg_valid), 0);
    stall_req = '0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(stg_valid == 6'b000001 && stg_tag[7:0] == 8'hD1, "R1 load",
          longint'(stg_tag[7:0]), 64'hD1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule